// File: doc/BRIEF.md
# Endian-Selectable Byte-Lane Memory Port

This block sits between a 32-bit register-side datapath and a small byte-addressable word memory that it holds itself. Each request gives a byte address, an access size (byte, halfword or word), a read or write strobe, write data, and a byte-order select. The block steers register bytes onto memory byte lanes in big-endian or little-endian order. It produces per-lane write enables for writes. For reads it returns the addressed bytes right-justified and zero-extended, registered one clock after the request.

The byte order is sampled with every request, so one steering path serves both layouts and software may change the order between any two accesses. Memory storage does not depend on the byte order: the byte at address `a` always sits in lane `a mod 4` of word `a div 4`. An access whose address is not a multiple of its size is refused. The memory is left untouched, read data is zero, and a one-cycle error pulse is raised.

Top module: `endian_lane_port`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `rdData`, `rdValid` and `misalign` are 0. Every memory byte reads as 0 until it is written.
- R2: `reqSize` encodes 0 = byte (1 byte), 1 = halfword (2 bytes), 2 = word (4 bytes). An access is aligned only if `reqAddr` is a multiple of that byte count. Code 3 is never aligned.
- R3: A valid misaligned request drives `misalign` high for exactly the cycle after it. That cycle `rdData` is 0, and no memory byte changes.
- R4: With `bigEndian` = 0, register byte k (bits 8k+7..8k) corresponds to byte address `reqAddr + k`.
- R5: With `bigEndian` = 1, register byte k of an N-byte access corresponds to byte address `reqAddr + N-1-k`. A word at address 0 therefore places address 0 in bits 31..24.
- R6: An aligned write changes exactly the N addressed bytes and no other byte of memory.
- R7: A read places its N bytes in bits 8N-1..0 of `rdData` and drives every higher bit to 0.
- R8: A valid read request, aligned or not, gives `rdValid` = 1 in the next cycle with its data. In any cycle not following a valid aligned read, `rdData` is 0. `rdValid` is 0 after writes and idle cycles.
- R9: The byte order is applied per request. Data written in one order and read in the other shows the byte-address mapping of each request, and changing `bigEndian` alone changes no stored byte.
- R10: A read, aligned or not, changes no memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Access size code (R2) |
| bigEndian | input | 1 | 1 = big-endian steering, 0 = little-endian |
| wrData | input | 32 | Write data, right-justified |
| rdData | output | 32 | Read data, right-justified, zero-extended |
| rdValid | output | 1 | Read result present |
| misalign | output | 1 | One-cycle misaligned-access pulse |

## Verification
Embedded assertions check on every cycle the rules that are visible locally:
- a size-3 request or an odd word address produces the error pulse;
- a write touches exactly as many lanes as its size;
- a refused request enables no lane and returns zero data;
- a read is followed by `rdValid`;
- a byte read is zero-extended.

Only the bench's reference model can show that the correct bytes reach the correct addresses in both orders. The same holds for neighbouring bytes surviving partial writes, refused writes leaving memory intact, and data written in one order reading back correctly in the other. For this the bench keeps a byte-level memory image and compares all outputs on every clock.

// File: rtl/elp_pkg.sv
package elp_pkg;
  localparam int LANES = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;      // aligned write accepted
    logic              rdEn;      // read accepted (aligned or not)
    logic              fault;     // misaligned request
    logic [LANES-1:0]  laneWe;    // per-lane write enable
    logic [LANES-1:0][1:0] srcLane; // lane used by register byte k
    logic [LANES-1:0]  keepByte;  // register byte k is part of access
  } strobe_t;
endpackage

// File: rtl/elp_ctrl.sv
module elp_ctrl
  import elp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqOffs,
  input  logic [1:0] reqSize,
  input  logic       bigEndian,
  output strobe_t    stb,
  output logic       misalign
);
  logic       aligned;
  logic [2:0] nBytes;
  logic       errQ;

  always_comb begin
    unique case (size_e'(reqSize))
      SZ_BYTE: begin aligned = 1'b1;            nBytes = 3'd1; end
      SZ_HALF: begin aligned = ~reqOffs[0];     nBytes = 3'd2; end
      SZ_WORD: begin aligned = (reqOffs == 2'd0); nBytes = 3'd4; end
      default: begin aligned = 1'b0;            nBytes = 3'd4; end
    endcase
  end

  always_comb begin
    logic [1:0] offs;
    stb = '0;
    stb.fault = reqValid & ~aligned;
    stb.wrEn  = reqValid & reqWrite & aligned;
    stb.rdEn  = reqValid & ~reqWrite;
    for (int k = 0; k < LANES; k++) begin
      stb.keepByte[k] = (3'(k) < nBytes);
      offs = bigEndian ? 2'(nBytes - 3'd1 - 3'(k)) : 2'(k);
      stb.srcLane[k] = reqOffs + offs;
      if (stb.wrEn && stb.keepByte[k])
        stb.laneWe[stb.srcLane[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= stb.fault;
  end
  assign misalign = errQ;

  // R2: size code 3 is always refused
  a_r2_bad_size: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3) |=> misalign);
  // R2: word at odd address is refused
  a_r2_odd_word: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd2 && reqOffs[0]) |=> misalign);
  // R3: pulse only follows a request
  a_r3_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    (misalign && $past(rstN)) |-> $past(reqValid));
  // R6: write enables exactly the access width
  a_r6_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> ($countones(stb.laneWe) == (32'd1 << reqSize)));
endmodule

// File: rtl/elp_datapath.sv
module elp_datapath
  import elp_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [WORD_AW-1:0] wordIdx,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid
);
  localparam int WORDS = 1 << WORD_AW;

  logic [LANES-1:0][LANE_W-1:0] mem [WORDS];
  logic [LANES-1:0][LANE_W-1:0] laneData;
  logic [LANES-1:0][LANE_W-1:0] rdNext;
  logic [LANES-1:0][LANE_W-1:0] curWord;

  assign curWord = mem[wordIdx];

  // write steering: each lane picks the register byte mapped onto it
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    always_comb begin
      laneData[L] = '0;
      for (int k = 0; k < LANES; k++)
        if (stb.keepByte[k] && stb.srcLane[k] == 2'(L))
          laneData[L] = wrData[k*LANE_W +: LANE_W];
    end
  end

  // read steering: each register byte picks its lane
  always_comb begin
    for (int k = 0; k < LANES; k++)
      rdNext[k] = (stb.rdEn && !stb.fault && stb.keepByte[k])
                  ? curWord[stb.srcLane[k]] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      for (int L = 0; L < LANES; L++)
        if (stb.laneWe[L]) mem[wordIdx][L] <= laneData[L];
      rdData  <= rdNext;
      rdValid <= stb.rdEn;
    end
  end

  // R3: refused request enables no lane
  a_r3_no_write_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |-> (stb.laneWe == '0));
  // R3: refused request returns zero data
  a_r3_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |=> (rdData == '0));
  // R8: read result one cycle later
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> rdValid);
  // R8: no read, no data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> (rdData == '0 && !rdValid));
endmodule

// File: rtl/endian_lane_port.sv
module endian_lane_port
  import elp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              bigEndian,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              misalign
);
  localparam int WORD_AW = ADDR_W - 2;

  strobe_t stb;

  elp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffs(reqAddr[1:0]), .reqSize(reqSize), .bigEndian(bigEndian),
    .stb(stb), .misalign(misalign)
  );

  elp_datapath #(.WORD_AW(WORD_AW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIdx(reqAddr[ADDR_W-1:2]),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // R7: byte reads are zero-extended
  a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd0) |=> (rdData[31:8] == 24'd0));
  // R7: halfword reads are zero-extended
  a_r7_half_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd1) |=> (rdData[31:16] == 16'd0));
endmodule

// File: tb/endian_lane_port_test.sv
module endian_lane_port_test;
  localparam int ADDR_W = 8;
  localparam int MEMB = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, bigEndian = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rdValid, misalign;

  always #4 clk = ~clk;

  endian_lane_port #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .bigEndian(bigEndian),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .misalign(misalign)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [7:0] model [MEMB];
  logic [31:0] expData = '0;
  logic expValid = 1'b0, expErr = 1'b0;
  string expTag = "R1";

  task automatic compareNow();
    compared++;
    if (rdData !== expData || rdValid !== expValid || misalign !== expErr) begin
      mismatched++;
      $display("FAIL %s: got data=%h valid=%b err=%b expected data=%h valid=%b err=%b",
               expTag, rdData, rdValid, misalign, expData, expValid, expErr);
    end
  endtask

  // one clock: check previous result, then present a new request
  task automatic issue(input bit v, input bit w, input int a, input int s,
                       input bit big, input logic [31:0] d, input string tag);
    int n;
    bit ok;
    int ba;
    @(negedge clk);
    compareNow();
    reqValid = v; reqWrite = w; reqAddr = ADDR_W'(a); reqSize = 2'(s);
    bigEndian = big; wrData = d;
    n = (s == 3) ? 4 : (1 << s);
    ok = (s != 3) && ((a % n) == 0);
    expData = '0; expValid = 1'b0; expErr = 1'b0; expTag = tag;
    if (v) begin
      expErr = !ok;
      expValid = !w;
      if (ok) begin
        for (int k = 0; k < n; k++) begin
          ba = big ? (a + n - 1 - k) : (a + k);
          if (w) model[ba] = d[8*k +: 8];
          else   expData[8*k +: 8] = model[ba];
        end
      end
    end
  endtask

  task automatic idle(input string tag);
    issue(0, 0, 0, 0, 0, 32'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
    repeat (3) begin
      @(negedge clk);
      compareNow(); // R1 during reset
    end
    rstN = 1'b1;
    // R1: memory reads zero after reset
    for (int i = 0; i < 4; i++) issue(1, 0, i * 4, 2, i[0], 32'h0, "R1");
    // R4: little-endian word write, byte reads
    issue(1, 1, 0, 2, 0, 32'h11223344, "R4");
    for (int i = 0; i < 4; i++) issue(1, 0, i, 0, 0, 32'h0, "R4");
    issue(1, 0, 0, 2, 0, 32'h0, "R4");
    // R5: big-endian word write, halfword and byte reads
    issue(1, 1, 4, 2, 1, 32'hA1B2C3D4, "R5");
    issue(1, 0, 4, 0, 1, 32'h0, "R5");
    issue(1, 0, 4, 1, 1, 32'h0, "R5");
    issue(1, 0, 6, 1, 1, 32'h0, "R5");
    // R9: read the same bytes in the other order
    issue(1, 0, 4, 2, 0, 32'h0, "R9");
    issue(1, 0, 0, 2, 1, 32'h0, "R9");
    issue(1, 0, 2, 1, 0, 32'h0, "R9");
    // R6: partial writes keep neighbours
    issue(1, 1, 9, 0, 0, 32'hFFFFFF5A, "R6");
    issue(1, 1, 14, 1, 1, 32'h0000BEEF, "R6");
    issue(1, 0, 8, 2, 0, 32'h0, "R6");
    issue(1, 0, 12, 2, 1, 32'h0, "R6");
    // R7: zero extension of narrow reads
    issue(1, 0, 3, 0, 1, 32'h0, "R7");
    issue(1, 0, 14, 1, 0, 32'h0, "R7");
    // R2/R3: misaligned writes refused, memory intact
    issue(1, 1, 1, 1, 0, 32'hDEADBEEF, "R3");
    issue(1, 1, 2, 2, 1, 32'hDEADBEEF, "R3");
    issue(1, 1, 0, 3, 0, 32'hDEADBEEF, "R2");
    issue(1, 0, 5, 1, 0, 32'h0, "R3");
    issue(1, 0, 4, 3, 1, 32'h0, "R2");
    issue(1, 0, 0, 2, 0, 32'h0, "R3");
    issue(1, 0, 4, 2, 0, 32'h0, "R3");
    // R10: repeated reads leave memory as it was
    issue(1, 0, 8, 2, 1, 32'h0, "R10");
    issue(1, 0, 8, 2, 1, 32'h0, "R10");
    // R8: idle and write cycles give no read data
    idle("R8");
    issue(1, 1, 20, 2, 0, 32'h01020304, "R8");
    idle("R8");
    issue(1, 0, 20, 2, 0, 32'h0, "R8");
    idle("R8");
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int a = int'($urandom_range(0, MEMB - 1));
      int s = int'($urandom_range(0, 3));
      issue($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, s,
            $urandom_range(0, 1) == 1, $urandom, "R9");
    end
    idle("R8");
    idle("R8");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule